// File: doc/BRIEF.md
# One-Hot Address Integrity Checker

This block protects the decoded select lines of a small register file against fault injection. It takes the three binary addresses of the file: two read ports and one write port. Each is expanded into a one-hot select vector with one bit per register word. The vectors pass through a keep boundary, which synthesis may not fold into the decoder, and a checker then tests each vector against the binary address and the enable that produced it. The enable is constant one on the read ports, because a read address is always valid, and it is the write strobe on the write port.

Any inconsistency on any port raises a single error flag in the same cycle. The surrounding system treats that flag as a major alert. The block only reports: it does not correct the address and does not block the access. Bit flips in the binary address itself, before decoding, are left to a lockstep copy elsewhere in the chip.

The keep boundary has a flip input for each vector and one for the write enable seen by the checker. These XOR inputs stand in for glitches and let the design be exercised with injected faults. Parameters select whether checking exists at all, whether the enable is checked, and whether the hot bit's position is compared with the address. Asking for the position compare without the enable check is rejected at elaboration.

Top module: `ohc_addr_guard`

## Requirements
- R1: With all flip inputs zero, `err_o` is 0 for every combination of read addresses, write address and write strobe. Bit i of each decoded vector corresponds to address i, and the read ports are decoded with an enable that is always one.
- R2: When any single bit of a read-port flip input (`flip_a_i` or `flip_b_i`) is set, `err_o` is 1 in the same cycle. The flip input is XORed onto the decoded vector.
- R3: With the position compare on (`ADDR_CHECK`=1), a vector whose only set bit is at a position other than the binary address raises `err_o`.
- R4: A vector with two or more bits set raises `err_o` in both the position-compare mode and the count-only mode.
- R5: With the write strobe low, the decoded write vector is all zeros. Any set bit in it, caused by `flip_w_i`, is flagged as a spurious write enable on `err_o`.
- R6: When `flip_wen_i` is 1, the checker sees the inverted write strobe, and `err_o` is 1 unless the vector also happens to match that inverted enable.
- R7: `err_o` is the OR of the results of the read-A, read-B and write checks. A fault on any one port raises it no matter whether the other ports are clean.
- R8: With `ADDR_CHECK`=0 and `EN_CHECK`=1, a single hot bit at the wrong position is not flagged. A missing hot bit under an active enable, or two hot bits, is still flagged.
- R9: With `CHECK_EN`=0, `err_o` is 0 for every input, including every flip pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| raddr_a_i | input | ADDR_W | Binary address of read port A |
| raddr_b_i | input | ADDR_W | Binary address of read port B |
| waddr_i | input | ADDR_W | Binary address of the write port |
| wr_en_i | input | 1 | Write strobe; the enable for the write decoder and its check |
| flip_a_i | input | 2**ADDR_W | XOR mask applied to the decoded read-A vector at the keep boundary |
| flip_b_i | input | 2**ADDR_W | XOR mask applied to the decoded read-B vector at the keep boundary |
| flip_w_i | input | 2**ADDR_W | XOR mask applied to the decoded write vector at the keep boundary |
| flip_wen_i | input | 1 | Inverts the write enable as seen by the write-port checker |
| err_o | output | 1 | Combined integrity error, combinational |

## Verification
The bound checker module tests several facts on every input change. Clean inputs never raise the flag, and a single flipped read bit always does. A spurious write bit under a low strobe is always flagged, and a flipped write enable on an otherwise clean vector is always flagged. With checking disabled, the flag stays silent. Some cases depend on the configuration and can only be shown by the bench's sweeps across three instances built with different parameters. These are the moved-bit case, which the full mode catches and the count-only mode misses, the multi-bit patterns, and the OR across ports. The bench compares all three instances against a reference rule evaluated on each applied pattern.

// File: rtl/ohc_pkg.sv
package ohc_pkg;

    // Port slots of the guard; the write slot is the one with a real enable.
    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned SLOT_RD_A = 0;
    localparam int unsigned SLOT_RD_B = 1;
    localparam int unsigned SLOT_WR   = 2;

    // Classes of violation one checker can observe on its vector.
    typedef struct packed {
        logic multi;   // two or more bits set
        logic empty;   // no bit set while enable is high
        logic moved;   // single bit, but not at the binary address
        logic stray;   // any bit set while enable is low
    } viol_t;

endpackage

// File: rtl/ohc_encoder.sv
module ohc_encoder #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned OH_W   = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [OH_W-1:0]   vec_o
);

    // One comparator per word: bit i is hot when the address equals i.
    for (genvar i = 0; i < OH_W; i++) begin : g_bit
        assign vec_o[i] = en_i & (addr_i == ADDR_W'(i));
    end

endmodule

// File: rtl/ohc_keep.sv
module ohc_keep #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] out_o
);

    // Boundary between decoder and checker. The XOR keeps the two halves
    // from being merged into a constant and serves as the glitch point.
    assign out_o = in_i ^ flip_i;

endmodule

// File: rtl/ohc_port_check.sv
module ohc_port_check
    import ohc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned OH_W       = 1 << ADDR_W,
    parameter bit          ADDR_CHECK = 1'b1,
    parameter bit          EN_CHECK   = 1'b1
) (
    input  logic [OH_W-1:0]   vec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic              err_o
);

    // Prefix OR: seen[i] is set when any lower bit is hot.
    logic [OH_W-1:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 1; i < OH_W; i++) begin : g_prefix
        assign seen[i] = seen[i-1] | vec_i[i-1];
    end

    logic [OH_W-1:0] want;
    logic            any_hot;
    viol_t           viol_d;

    assign want    = OH_W'(1) << addr_i;
    assign any_hot = |vec_i;

    always_comb begin
        viol_d       = '0;
        viol_d.multi = |(vec_i & seen);
        if (EN_CHECK) begin
            viol_d.empty = en_i & ~any_hot;
            viol_d.stray = ~en_i & any_hot;
            if (ADDR_CHECK) begin
                viol_d.moved = en_i & (vec_i != want);
            end
        end
    end

    assign err_o = |viol_d;

endmodule

// File: rtl/ohc_addr_guard.sv
module ohc_addr_guard
    import ohc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter bit          CHECK_EN   = 1'b1,
    parameter bit          ADDR_CHECK = 1'b1,
    parameter bit          EN_CHECK   = 1'b1,
    localparam int unsigned OH_W      = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] raddr_a_i,
    input  logic [ADDR_W-1:0] raddr_b_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic              wr_en_i,
    input  logic [OH_W-1:0]   flip_a_i,
    input  logic [OH_W-1:0]   flip_b_i,
    input  logic [OH_W-1:0]   flip_w_i,
    input  logic              flip_wen_i,
    output logic              err_o
);

    if (ADDR_CHECK && !EN_CHECK) begin : g_bad_cfg
        $error("ohc_addr_guard: position compare requires the enable check");
    end

    logic [ADDR_W-1:0]    addr_arr [NUM_PORTS];
    logic [OH_W-1:0]      flip_arr [NUM_PORTS];
    logic [NUM_PORTS-1:0] en_enc;
    logic [NUM_PORTS-1:0] en_chk;
    logic [NUM_PORTS-1:0] port_err;

    assign addr_arr[SLOT_RD_A] = raddr_a_i;
    assign addr_arr[SLOT_RD_B] = raddr_b_i;
    assign addr_arr[SLOT_WR]   = waddr_i;
    assign flip_arr[SLOT_RD_A] = flip_a_i;
    assign flip_arr[SLOT_RD_B] = flip_b_i;
    assign flip_arr[SLOT_WR]   = flip_w_i;

    // Read addresses are always valid; the write port uses its strobe.
    assign en_enc = {wr_en_i, 1'b1, 1'b1};
    assign en_chk = en_enc ^ {flip_wen_i, 1'b0, 1'b0};

    if (CHECK_EN) begin : g_on
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [OH_W-1:0] vec_raw;
            logic [OH_W-1:0] vec_kept;

            ohc_encoder #(
                .ADDR_W (ADDR_W),
                .OH_W   (OH_W)
            ) u_enc (
                .addr_i (addr_arr[p]),
                .en_i   (en_enc[p]),
                .vec_o  (vec_raw)
            );

            ohc_keep #(
                .W (OH_W)
            ) u_keep (
                .in_i   (vec_raw),
                .flip_i (flip_arr[p]),
                .out_o  (vec_kept)
            );

            ohc_port_check #(
                .ADDR_W     (ADDR_W),
                .OH_W       (OH_W),
                .ADDR_CHECK (ADDR_CHECK),
                .EN_CHECK   (EN_CHECK)
            ) u_chk (
                .vec_i  (vec_kept),
                .addr_i (addr_arr[p]),
                .en_i   (en_chk[p]),
                .err_o  (port_err[p])
            );
        end
    end else begin : g_off
        assign port_err = '0;
    end

    // Aggregation: any port in error raises the alert.
    always_comb begin
        err_o = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            err_o = err_o | port_err[p];
        end
    end

endmodule

// File: rtl/ohc_addr_guard_chk.sv
module ohc_addr_guard_chk #(
    parameter int unsigned ADDR_W     = 5,
    parameter bit          CHECK_EN   = 1'b1,
    parameter bit          EN_CHECK   = 1'b1,
    localparam int unsigned OH_W      = 1 << ADDR_W
) (
    input logic [ADDR_W-1:0] raddr_a_i,
    input logic [ADDR_W-1:0] raddr_b_i,
    input logic [ADDR_W-1:0] waddr_i,
    input logic              wr_en_i,
    input logic [OH_W-1:0]   flip_a_i,
    input logic [OH_W-1:0]   flip_b_i,
    input logic [OH_W-1:0]   flip_w_i,
    input logic              flip_wen_i,
    input logic              err_o
);

    logic known;
    logic clean;

    assign known = !$isunknown({raddr_a_i, raddr_b_i, waddr_i, wr_en_i,
                                flip_a_i, flip_b_i, flip_w_i, flip_wen_i, err_o});
    assign clean = (flip_a_i == '0) && (flip_b_i == '0) && (flip_w_i == '0) && !flip_wen_i;

    always_comb begin
        if (known) begin
            // R1: no injected fault, no alert
            a_r1_clean_silent: assert (!(CHECK_EN && clean) || !err_o);
            // R2: a single flipped read-A bit is always caught
            a_r2_single_flip: assert (!(CHECK_EN && $countones(flip_a_i) == 1) || err_o);
            // R5: stray write bit under a low strobe
            a_r5_spurious_write: assert (!(CHECK_EN && EN_CHECK && !wr_en_i && !flip_wen_i
                                           && flip_w_i != '0) || err_o);
            // R6: flipped write enable on an unflipped write vector
            a_r6_wen_glitch: assert (!(CHECK_EN && EN_CHECK && flip_wen_i && flip_w_i == '0)
                                     || err_o);
            // R9: checking disabled keeps the alert low
            a_r9_disabled: assert (CHECK_EN || !err_o);
        end
    end

endmodule

bind ohc_addr_guard ohc_addr_guard_chk #(
    .ADDR_W   (ADDR_W),
    .CHECK_EN (CHECK_EN),
    .EN_CHECK (EN_CHECK)
) u_guard_chk (.*);

// File: tb/ohc_addr_guard_test.sv
module ohc_addr_guard_test;

    localparam int AW = 5;
    localparam int OW = 1 << AW;

    logic          clk = 1'b0;
    logic [AW-1:0] ra, rb, wa;
    logic          wen;
    logic [OW-1:0] fa, fb, fw;
    logic          fwen;
    logic          err_full, err_cnt, err_off;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ohc_addr_guard #(.ADDR_W(AW)) uut (
        .raddr_a_i(ra), .raddr_b_i(rb), .waddr_i(wa), .wr_en_i(wen),
        .flip_a_i(fa), .flip_b_i(fb), .flip_w_i(fw), .flip_wen_i(fwen),
        .err_o(err_full));

    ohc_addr_guard #(.ADDR_W(AW), .ADDR_CHECK(1'b0)) uut_cnt (
        .raddr_a_i(ra), .raddr_b_i(rb), .waddr_i(wa), .wr_en_i(wen),
        .flip_a_i(fa), .flip_b_i(fb), .flip_w_i(fw), .flip_wen_i(fwen),
        .err_o(err_cnt));

    ohc_addr_guard #(.ADDR_W(AW), .CHECK_EN(1'b0)) uut_off (
        .raddr_a_i(ra), .raddr_b_i(rb), .waddr_i(wa), .wr_en_i(wen),
        .flip_a_i(fa), .flip_b_i(fb), .flip_w_i(fw), .flip_wen_i(fwen),
        .err_o(err_off));

    // Rule for one port, taken from the requirements.
    function automatic bit port_bad(logic [OW-1:0] v, logic [AW-1:0] a, logic e, bit ac);
        int n = $countones(v);
        if (!e) return v != '0;
        if (n != 1) return 1'b1;
        if (ac) return v != (OW'(1) << a);
        return 1'b0;
    endfunction

    function automatic bit model(bit ac);
        logic [OW-1:0] va = (OW'(1) << ra) ^ fa;
        logic [OW-1:0] vb = (OW'(1) << rb) ^ fb;
        logic [OW-1:0] vw = (wen ? (OW'(1) << wa) : OW'(0)) ^ fw;
        return port_bad(va, ra, 1'b1, ac) | port_bad(vb, rb, 1'b1, ac)
             | port_bad(vw, wa, wen ^ fwen, ac);
    endfunction

    task automatic cmp(string req, string inst, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: err=%b expected %b (ra=%0d rb=%0d wa=%0d wen=%b)",
                     req, inst, got, exp, ra, rb, wa, wen);
        end
    endtask

    // Inputs change mid-cycle; outputs are combinational, sampled 5 ns later.
    task automatic apply_check(string req);
        @(negedge clk);
        #5;
        cmp(req, "full", err_full, model(1'b1));
        cmp(req, "count", err_cnt, model(1'b0));
        cmp(req, "off", err_off, 1'b0);
    endtask

    task automatic clear();
        fa = '0; fb = '0; fw = '0; fwen = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    logic [31:0] lfsr;

    initial begin
        ra = '0; rb = '0; wa = '0; wen = 1'b0;
        clear();
        // R1: idle state
        @(negedge clk); #5;
        cmp("R1", "full", err_full, 1'b0);
        cmp("R1", "off", err_off, 1'b0);

        // R1: all addresses, both strobe values, clean
        for (int a = 0; a < OW; a++) begin
            for (int s = 0; s < 2; s++) begin
                ra = AW'(a); rb = AW'(OW - 1 - a); wa = AW'(a + 7); wen = s[0];
                apply_check("R1");
                cmp("R1", "full_const", err_full, 1'b0);
            end
        end

        // R2: every single-bit flip on read ports A and B
        for (int a = 0; a < OW; a++) begin
            for (int k = 0; k < OW; k++) begin
                clear(); ra = AW'(a); rb = AW'(k); wen = 1'b0;
                fa = OW'(1) << k;
                apply_check("R2");
                cmp("R2", "full_const", err_full, 1'b1);
                clear(); fb = OW'(1) << a;
                apply_check("R2");
            end
        end

        // R3 / R8: hot bit moved to the neighbour position
        for (int a = 0; a < OW; a++) begin
            clear(); ra = AW'(a); rb = '0; wen = 1'b0;
            fa = (OW'(1) << a) | (OW'(1) << ((a + 1) % OW));
            apply_check("R3");
            cmp("R3", "full_const", err_full, 1'b1);
            cmp("R8", "count_const", err_cnt, 1'b0);
        end

        // R4: two and three hot bits on read port B
        for (int a = 0; a < OW; a++) begin
            clear(); rb = AW'(a); ra = '0;
            fb = OW'(1) << ((a + 3) % OW);
            apply_check("R4");
            cmp("R4", "count_const", err_cnt, 1'b1);
            fb = fb | (OW'(1) << ((a + 9) % OW));
            apply_check("R4");
            cmp("R4", "full_const", err_full, 1'b1);
        end

        // R5: stray bit on the write vector with strobe low
        for (int k = 0; k < OW; k++) begin
            clear(); ra = 3; rb = 4; wa = AW'(k); wen = 1'b0;
            fw = OW'(1) << k;
            apply_check("R5");
            cmp("R5", "full_const", err_full, 1'b1);
        end

        // R6: write enable glitch with either strobe value
        for (int s = 0; s < 2; s++) begin
            clear(); wa = 5'd17; wen = s[0]; fwen = 1'b1;
            apply_check("R6");
            cmp("R6", "full_const", err_full, 1'b1);
            cmp("R8", "count_const", err_cnt, 1'b1);
        end
        // R6: glitch masked when the vector also matches the inverted enable
        clear(); wa = 5'd17; wen = 1'b0; fwen = 1'b1; fw = OW'(1) << 17;
        apply_check("R6");
        cmp("R6", "full_const", err_full, 1'b0);

        // R8: read port with no bit at all under active enable
        clear(); ra = 5'd9; fa = OW'(1) << 9;
        apply_check("R8");
        cmp("R8", "count_const", err_cnt, 1'b1);

        // R7: pseudo-random sparse faults across all ports
        lfsr = 32'hACE1_2468;
        for (int it = 0; it < 3000; it++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr[4:0]; rb = lfsr[9:5]; wa = lfsr[14:10]; wen = lfsr[15];
            clear();
            case (lfsr[18:16])
                3'd0: fa = OW'(1) << lfsr[23:19];
                3'd1: fb = (OW'(1) << lfsr[23:19]) | (OW'(1) << lfsr[28:24]);
                3'd2: fw = OW'(1) << lfsr[23:19];
                3'd3: fwen = 1'b1;
                3'd4: begin fa = OW'(1) << ra; fa[lfsr[23:19]] = 1'b1; end
                default: ;
            endcase
            apply_check("R7");
        end
        // R7: only the write port faulty, read ports clean
        clear(); ra = 1; rb = 2; wa = 3; wen = 1'b1; fw = OW'(1) << 30;
        apply_check("R7");
        cmp("R7", "full_const", err_full, 1'b1);
        // R9: every fault source at once, disabled instance silent
        fa = '1; fb = 32'h5555_0001; fwen = 1'b1;
        apply_check("R9");
        cmp("R9", "off_const", err_off, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule